// File: doc/BRIEF.md
# Two-Mode Serial Clock Divider

This block derives the serial clock of an SPI master from its module clock. A 13-bit clock control word holds two divider fields and a select bit. One field sets an even linear divide ratio in steps of two. The other sets a power-of-two ratio, which reaches the slow rates that the linear field cannot. The block drives a square serial clock with 50% duty. It also drives two single-cycle strobes that tell the shift engine when the clock has just risen or just fallen.

The shift controller raises `run` to start clocking and lowers it to stop. While `run` is low the clock rests at the level given by `cpol` and no strobes appear. Software may rewrite the control word at any time. The new ratio is only adopted at the end of the half period in progress, so the clock never carries a shortened high or low phase. There is no data stream at this block's edge, so every pin is a plain control or status signal with no handshake.

Top module: `spi_sclk_gen`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `sclk`, `sclk_rise` and `sclk_fall` are all low.
- R2: With bit 12 of `clk_cfg` at 1, the divider is linear: each half period lasts N+1 module clock cycles, where N is `clk_cfg[7:0]`. Bits 11:8 have no effect in this mode.
- R3: With bit 12 of `clk_cfg` at 0, the divider is a power of two: each half period lasts 2^M module clock cycles, where M is `clk_cfg[11:8]`. Bits 7:0 have no effect in this mode.
- R4: In steady clocking, the high phase and the low phase have equal length, so the duty cycle is 50%.
- R5: `sclk_rise` is high for exactly the one cycle in which `sclk` first reads 1 after a low phase. `sclk_fall` is high for exactly the one cycle in which `sclk` first reads 0 after a high phase. Every change of `sclk` during clocking carries exactly one of these strobes.
- R6: The first edge after `run` rises comes one full half period after the first clock edge that samples `run` high. That first edge leads away from the `cpol` level.
- R7: A change to N while clocking does not alter the half period in progress. The new length applies from the next half period.
- R8: A change of the mode-select bit while clocking also takes effect only at the next half-period boundary.
- R9: One cycle after `run` is sampled low, `sclk` equals `cpol`, and no strobe is produced while `run` stays low.
- R10: The internal half-period counter never reaches the loaded half-period length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_cfg | input | 13 | Clock control word: [7:0] linear N, [11:8] exponent M, [12] mode select (1 linear, 0 power of two) |
| cpol | input | 1 | Idle level of the serial clock |
| run | input | 1 | High while the shift controller wants the clock running |
| sclk | output | 1 | Serial clock |
| sclk_rise | output | 1 | One-cycle strobe in the first cycle of a high phase |
| sclk_fall | output | 1 | One-cycle strobe in the first cycle of a low phase |

## Verification
The hardest case to reach from the ports is a control word rewritten in the middle of a half period. That covers both a new linear N and a flip of the mode bit. The stimulus must land strictly between two boundaries, and it must then show that the running phase keeps its old length while every later phase takes the new one. The driver counts module clock cycles from the moment it raises `run`. It rewrites the word a chosen number of cycles into the first half period. It then queues one gap at the old length followed by gaps at the new length. The monitor times the gap between consecutive strobes and compares each gap against the queue.

// File: rtl/spi_clkdiv_pkg.sv
package spi_clkdiv_pkg;

  // Value of the mode-select bit in the control word.
  typedef enum logic {
    DIV_POW2   = 1'b0,
    DIV_LINEAR = 1'b1
  } div_mode_e;

  // Width of a half-period counter that covers both modes.
  function automatic int half_cnt_width(input int lin_w, input int exp_w);
    int exp_need;
    exp_need = (1 << exp_w);
    return ((lin_w + 1) > exp_need) ? (lin_w + 1) : exp_need;
  endfunction

endpackage

// File: rtl/sclk_cfg_decode.sv
module sclk_cfg_decode
  import spi_clkdiv_pkg::*;
#(
  parameter int LIN_W = 8,
  parameter int EXP_W = 4,
  parameter int CNT_W = 16,
  parameter int CFG_W = LIN_W + EXP_W + 1
) (
  input  logic [CFG_W-1:0] cfg,
  output logic [CNT_W-1:0] half_len
);

  localparam int SEL_POS = LIN_W + EXP_W;

  div_mode_e             mode;
  logic [LIN_W-1:0]      lin_n;
  logic [EXP_W-1:0]      exp_m;
  logic [CNT_W-1:0]      len_lin;
  logic [CNT_W-1:0]      len_pow;

  always_comb begin
    mode     = div_mode_e'(cfg[SEL_POS]);
    lin_n    = cfg[LIN_W-1:0];
    exp_m    = cfg[LIN_W +: EXP_W];
    len_lin  = CNT_W'(lin_n) + CNT_W'(1);
    len_pow  = CNT_W'(1) << exp_m;
    half_len = (mode == DIV_LINEAR) ? len_lin : len_pow;
  end

  // R3: a decoded half period is never empty in either mode
  always_comb begin
    a_r3_half_nonzero: assert (half_len != '0);
  end

endmodule

// File: rtl/sclk_half_timer.sv
module sclk_half_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] half_new,
  output logic             tick
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] half_q;
  logic             at_end;

  assign at_end = (cnt_q == half_q - CNT_W'(1));
  assign tick   = run && at_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      half_q <= CNT_W'(1);
    end else if (!run) begin
      cnt_q  <= '0;
      half_q <= half_new;
    end else if (at_end) begin
      cnt_q  <= '0;
      half_q <= half_new;
    end else begin
      cnt_q  <= cnt_q + CNT_W'(1);
    end
  end

  // R10: counter stays below the loaded half length
  a_r10_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < half_q);

  // R7: loaded length only changes at a boundary or while idle
  a_r7_reload_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && !$past(tick)) |-> $stable(half_q));

endmodule

// File: rtl/sclk_edge_out.sv
module sclk_edge_out (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic cpol,
  input  logic tick,
  output logic sclk,
  output logic rise_stb,
  output logic fall_stb
);

  logic sclk_q, rise_q, fall_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else if (!run) begin
      sclk_q <= cpol;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else if (tick) begin
      sclk_q <= ~sclk_q;
      rise_q <= ~sclk_q;
      fall_q <= sclk_q;
    end else begin
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end
  end

  assign sclk     = sclk_q;
  assign rise_stb = rise_q;
  assign fall_stb = fall_q;

  // R9: idle returns the clock to its rest level with no strobes
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (sclk == $past(cpol)) && !rise_stb && !fall_stb);

  // R5: while clocking, every change of sclk carries a strobe and vice versa
  a_r5_change_has_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $past(run) |-> ((sclk != $past(sclk)) == (rise_stb || fall_stb)));

endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen
  import spi_clkdiv_pkg::*;
#(
  parameter int LIN_W = 8,
  parameter int EXP_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [LIN_W+EXP_W:0]     clk_cfg,
  input  logic                     cpol,
  input  logic                     run,
  output logic                     sclk,
  output logic                     sclk_rise,
  output logic                     sclk_fall
);

  localparam int CFG_W = LIN_W + EXP_W + 1;
  localparam int CNT_W = half_cnt_width(LIN_W, EXP_W);

  logic [CNT_W-1:0] half_new;
  logic             tick;

  sclk_cfg_decode #(
    .LIN_W (LIN_W),
    .EXP_W (EXP_W),
    .CNT_W (CNT_W),
    .CFG_W (CFG_W)
  ) u_decode (
    .cfg      (clk_cfg),
    .half_len (half_new)
  );

  sclk_half_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .half_new (half_new),
    .tick     (tick)
  );

  sclk_edge_out u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .cpol     (cpol),
    .tick     (tick),
    .sclk     (sclk),
    .rise_stb (sclk_rise),
    .fall_stb (sclk_fall)
  );

  // R5: the two strobes never coincide
  a_r5_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(sclk_rise && sclk_fall));

endmodule

// File: tb/spi_sclk_gen_tb.sv
module spi_sclk_gen_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] clk_cfg = 13'h1000;
  logic        cpol = 1'b0;
  logic        run = 1'b0;
  logic        sclk, sclk_rise, sclk_fall;

  int checks = 0;
  int failures = 0;
  int gap = 0;
  bit done = 1'b0;

  typedef struct {
    int    len;
    bit    is_rise;
    string tag;
  } exp_t;

  exp_t expq[$];

  always #2 clk = ~clk;

  spi_sclk_gen u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_cfg   (clk_cfg),
    .cpol      (cpol),
    .run       (run),
    .sclk      (sclk),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [12:0] mk(input bit sel, input int m, input int n);
    return {sel, 4'(m), 8'(n)};
  endfunction

  // Queue n strobes of spacing h, the first leading away from pol.
  task automatic push_run(input bit pol, input int h, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.len = h;
      e.is_rise = (pol == 1'b0) ? (i % 2 == 0) : (i % 2 == 1);
      e.tag = tag;
      expq.push_back(e);
    end
  endtask

  task automatic idle_check(input bit pol, input string req);
    repeat (4) @(negedge clk);
    chk(sclk == pol && !sclk_rise && !sclk_fall, req, "idle level", sclk, pol);
  endtask

  task automatic run_case(input logic [12:0] cfg, input bit pol,
                          input int h, input int n, input string tag);
    @(negedge clk);
    clk_cfg = cfg;
    cpol = pol;
    idle_check(pol, "R9");
    push_run(pol, h, n, tag);
    run = 1'b1;
    gap = 0;
    repeat (h * n) @(negedge clk);
    run = 1'b0;
    idle_check(pol, "R9");
  endtask

  // Rewrite the control word d cycles into the first half period.
  task automatic run_change(input logic [12:0] cfg1, input int h1,
                            input logic [12:0] cfg2, input int h2,
                            input int n, input int d, input string tag);
    exp_t e;
    @(negedge clk);
    clk_cfg = cfg1;
    cpol = 1'b0;
    idle_check(1'b0, "R9");
    e.len = h1;
    e.is_rise = 1'b1;
    e.tag = tag;
    expq.push_back(e);
    for (int i = 1; i < n; i++) begin
      exp_t f;
      f.len = h2;
      f.is_rise = (i % 2 == 0);
      f.tag = tag;
      expq.push_back(f);
    end
    run = 1'b1;
    gap = 0;
    repeat (d) @(negedge clk);
    clk_cfg = cfg2;
    repeat (h1 + (n - 1) * h2 - d) @(negedge clk);
    run = 1'b0;
    idle_check(1'b0, "R9");
  endtask

  // Monitor: time the gap between strobes and compare against the queue.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      gap++;
      if (sclk_rise || sclk_fall) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R9", "unexpected strobe", 1, 0);
        end else begin
          exp_t e;
          e = expq.pop_front();
          chk(gap == e.len, e.tag, "half period length", gap, e.len);
          chk(sclk_rise == e.is_rise && sclk_fall == !e.is_rise, "R5",
              "strobe kind", sclk_rise, e.is_rise);
          chk(sclk == sclk_rise, "R5", "level at strobe", sclk, sclk_rise);
        end
        gap = 0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(sclk == 1'b0 && !sclk_rise && !sclk_fall, "R1", "in reset", sclk, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sclk == 1'b0 && !sclk_rise && !sclk_fall, "R1", "after reset", sclk, 0);

    // R2: linear, N=0 gives the fastest clock
    run_case(mk(1'b1, 0, 0), 1'b0, 1, 6, "R2");
    // R2: linear N=2, exponent field filled with ones must be ignored
    run_case(mk(1'b1, 15, 2), 1'b0, 3, 6, "R2");
    // R2/R4: linear N=255, the widest linear ratio
    run_case(mk(1'b1, 0, 255), 1'b0, 256, 4, "R4");
    // R3: power of two, M=0 with linear field ignored
    run_case(mk(1'b0, 0, 200), 1'b0, 1, 6, "R3");
    // R3: M=3
    run_case(mk(1'b0, 3, 7), 1'b0, 8, 6, "R3");
    // R3/R4: M=10
    run_case(mk(1'b0, 10, 0), 1'b0, 1024, 2, "R3");
    // R6: idle high, first edge falls
    run_case(mk(1'b1, 0, 1), 1'b1, 2, 6, "R6");
    // R6: idle high in power-of-two mode
    run_case(mk(1'b0, 2, 0), 1'b1, 4, 4, "R6");
    // R7: linear N=3 rewritten to N=1 two cycles into the first half
    run_change(mk(1'b1, 0, 3), 4, mk(1'b1, 0, 1), 2, 5, 2, "R7");
    // R8: linear N=5 switched to power of two M=1 mid half
    run_change(mk(1'b1, 0, 5), 6, mk(1'b0, 1, 5), 2, 5, 3, "R8");
    // R8: power of two M=2 switched to linear N=0 mid half
    run_change(mk(1'b0, 2, 0), 4, mk(1'b1, 2, 0), 1, 4, 1, "R8");

    repeat (4) @(negedge clk);
    chk(expq.size() == 0, "R5", "strobes missing", expq.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule